// File: doc/BRIEF.md
# SDRAM Command Decoder and Bank Tracker

This block is the control front end of a four-bank synchronous DRAM. On every rising clock edge it samples the clock-enable, chip-select, the three strobe inputs, the bank field and the address bus. It turns them into one command and keeps a per-bank record of whether a row is open and which row it is. It also holds the mode settings that a mode-register command loads from the address bus. Commands that do not fit the tracked state are flagged and have no effect.

The clock-enable is registered. A low sample freezes command decoding from the following edge on. The same register also tracks the self-refresh state, which is entered through the refresh encoding taken with the clock-enable falling. The cell array, the data path and burst counting belong to neighbouring blocks. Those blocks read the decoded command, the bank record and the mode settings from this block's outputs.

Top module: `sdram_cmd_tracker`

## Requirements
- R1: During and right after synchronous reset, every bank is idle, every stored row is zero, `cmd_o` is 0, `err_o`, `frozen_o`, `self_ref_o` and `burst_ilv_o` are 0, `burst_len_o` is 0 and `cas_lat_o` is 2.
- R2: One edge after sampling, `cmd_o` reports the command. With the clock-enable high on the previous edge and chip-select low, {ras_n,cas_n,we_n} decodes as follows: 000 gives 1 (mode set); 001 gives 2 (auto refresh) if the current clock-enable is high, otherwise 3 (self-refresh entry); 011 gives 4 (activate); 101 gives 5 (read); 100 gives 6 (write); 110 gives 7 (burst stop); 010 gives 8 (precharge); 111 gives 0. Chip-select high always gives 0 and changes no state.
- R3: `frozen_o` shows the inverse of the clock-enable sampled on the last edge. While it is 1, the next edge decodes as 0 and changes no bank or mode state.
- R4: An activate to an idle bank opens it and stores the 12-bit address as its row. An activate to an open bank raises `err_o` and leaves its state and row unchanged.
- R5: A read or write to an idle bank raises `err_o` and changes nothing. To an open bank it raises no error, and the bank closes when address bit 10 is 1 and stays open when bit 10 is 0.
- R6: A precharge with address bit 10 at 1 closes every bank and never raises an error. With bit 10 at 0 it closes the selected open bank, or raises `err_o` if that bank is idle.
- R7: A mode set with all banks idle loads `burst_len_o` from address bits 2:0, `burst_ilv_o` from bit 3 and `cas_lat_o` from bits 6:4, and the values hold until the next accepted mode set. With any bank open it raises `err_o` and the settings stay unchanged.
- R8: An auto refresh with all banks idle raises no error and changes no state. With any bank open it raises `err_o`.
- R9: A self-refresh entry with all banks idle sets `self_ref_o`, which stays set until an edge that samples the clock-enable high after a low sample. With any bank open it raises `err_o` and `self_ref_o` stays 0.
- R10: The bank field value selects the bank of the same index (bank b's row at `open_row_o[12*b +: 12]`, its state at `bank_open_o[b]`). `err_o` is a registered flag that covers only the command sampled on the previous edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| cke_i | input | 1 | Clock-enable |
| cs_n_i | input | 1 | Chip select, active low |
| ras_n_i | input | 1 | Row strobe, active low |
| cas_n_i | input | 1 | Column strobe, active low |
| we_n_i | input | 1 | Write strobe, active low |
| ba_i | input | 2 | Bank field |
| addr_i | input | 12 | Multiplexed row/column/key address |
| cmd_o | output | 4 | Decoded command code |
| err_o | output | 1 | Illegal-command flag |
| bank_open_o | output | 4 | Open flag per bank |
| open_row_o | output | 48 | Stored row per bank |
| cas_lat_o | output | 3 | Read latency setting |
| burst_len_o | output | 3 | Burst length code |
| burst_ilv_o | output | 1 | Interleaved burst order |
| frozen_o | output | 1 | Decoding frozen this cycle |
| self_ref_o | output | 1 | Self-refresh active |

## Verification
The assertions check, on every cycle, the rules that tie one edge to the next. A frozen cycle decodes as no-op, self-refresh implies frozen, an illegal command leaves the bank record or the mode settings untouched, an accepted activate captures its row, and an all-bank precharge leaves every bank idle. The bench scenarios are what show that the encodings decode to the stated codes, that the key fields land in the stated bit positions, and that the bank field picks the right bank. They also cover longer sequences: a freeze followed by its release, self-refresh entry followed by exit, and a mode set accepted again once the banks have been closed.

// File: rtl/sdc_pkg.sv
package sdc_pkg;
  typedef enum logic [3:0] {
    CMD_NOP  = 4'd0,
    CMD_MRS  = 4'd1,
    CMD_REF  = 4'd2,
    CMD_SREF = 4'd3,
    CMD_ACT  = 4'd4,
    CMD_RD   = 4'd5,
    CMD_WR   = 4'd6,
    CMD_BST  = 4'd7,
    CMD_PRE  = 4'd8
  } cmd_e;
endpackage

// File: rtl/sdc_decode.sv
module sdc_decode
  import sdc_pkg::*;
(
  input  logic cke_prev,
  input  logic cke_now,
  input  logic cs_n,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  output cmd_e cmd
);
  always_comb begin
    cmd = CMD_NOP;
    if (cke_prev && !cs_n) begin
      case ({ras_n, cas_n, we_n})
        3'b000:  cmd = CMD_MRS;
        3'b001:  cmd = cke_now ? CMD_REF : CMD_SREF;
        3'b011:  cmd = CMD_ACT;
        3'b101:  cmd = CMD_RD;
        3'b100:  cmd = CMD_WR;
        3'b110:  cmd = CMD_BST;
        3'b010:  cmd = CMD_PRE;
        default: cmd = CMD_NOP;
      endcase
    end
  end
endmodule

// File: rtl/sdc_bank.sv
module sdc_bank
  import sdc_pkg::*;
#(
  parameter int ROW_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  cmd_e             cmd,
  input  logic             sel,
  input  logic             ap,
  input  logic [ROW_W-1:0] row_in,
  output logic             open_o,
  output logic [ROW_W-1:0] row_o,
  output logic             illegal_o
);
  logic act_ok, col_close, pre_close;

  always_comb begin
    illegal_o = 1'b0;
    case (cmd)
      CMD_ACT:        illegal_o = sel && open_o;
      CMD_RD, CMD_WR: illegal_o = sel && !open_o;
      CMD_PRE:        illegal_o = sel && !ap && !open_o;
      default:        illegal_o = 1'b0;
    endcase
  end

  assign act_ok    = (cmd == CMD_ACT) && sel && !open_o;
  assign col_close = ((cmd == CMD_RD) || (cmd == CMD_WR)) && sel && open_o && ap;
  assign pre_close = (cmd == CMD_PRE) && (ap || (sel && open_o));

  always_ff @(posedge clk) begin
    if (rst) begin
      open_o <= 1'b0;
      row_o  <= '0;
    end else if (act_ok) begin
      open_o <= 1'b1;
      row_o  <= row_in;
    end else if (col_close || pre_close) begin
      open_o <= 1'b0;
    end
  end

  assert_illegal_keeps_bank_R4: assert property (@(posedge clk) disable iff (rst)
    illegal_o |=> ($stable(open_o) && $stable(row_o)));

  assert_act_captures_row_R4: assert property (@(posedge clk) disable iff (rst)
    ((cmd == CMD_ACT) && sel && !open_o) |=> (open_o && (row_o == $past(row_in))));

  assert_pre_all_closes_R6: assert property (@(posedge clk) disable iff (rst)
    ((cmd == CMD_PRE) && ap) |=> !open_o);
endmodule

// File: rtl/sdc_mode.sv
module sdc_mode
  import sdc_pkg::*;
#(
  parameter int         BL_W   = 3,
  parameter int         CL_W   = 3,
  parameter logic [2:0] CL_RST = 3'd2
) (
  input  logic            clk,
  input  logic            rst,
  input  cmd_e            cmd,
  input  logic            cke_prev,
  input  logic            cke_now,
  input  logic            any_open,
  input  logic [BL_W+CL_W:0] key,
  output logic [CL_W-1:0] cas_lat_o,
  output logic [BL_W-1:0] burst_len_o,
  output logic            burst_ilv_o,
  output logic            self_ref_o,
  output logic            illegal_o
);
  localparam int ILV_POS = BL_W;
  localparam int CL_LSB  = BL_W + 1;

  logic needs_idle;

  assign needs_idle = (cmd == CMD_MRS) || (cmd == CMD_REF) || (cmd == CMD_SREF);
  assign illegal_o  = needs_idle && any_open;

  always_ff @(posedge clk) begin
    if (rst) begin
      cas_lat_o   <= CL_W'(CL_RST);
      burst_len_o <= '0;
      burst_ilv_o <= 1'b0;
    end else if ((cmd == CMD_MRS) && !any_open) begin
      cas_lat_o   <= key[CL_LSB +: CL_W];
      burst_len_o <= key[BL_W-1:0];
      burst_ilv_o <= key[ILV_POS];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      self_ref_o <= 1'b0;
    end else if (!cke_prev && cke_now) begin
      self_ref_o <= 1'b0;
    end else if ((cmd == CMD_SREF) && !any_open) begin
      self_ref_o <= 1'b1;
    end
  end

  assert_blocked_mrs_keeps_mode_R7: assert property (@(posedge clk) disable iff (rst)
    illegal_o |=> ($stable(cas_lat_o) && $stable(burst_len_o) && $stable(burst_ilv_o)));

  assert_sref_exit_R9: assert property (@(posedge clk) disable iff (rst)
    (self_ref_o && !cke_prev && cke_now) |=> !self_ref_o);

  assert_blocked_sref_R9: assert property (@(posedge clk) disable iff (rst)
    ((cmd == CMD_SREF) && any_open && !self_ref_o) |=> !self_ref_o);
endmodule

// File: rtl/sdram_cmd_tracker.sv
module sdram_cmd_tracker
  import sdc_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int ROW_W     = 12,
  parameter int AP_BIT    = 10,
  parameter int BL_W      = 3,
  parameter int CL_W      = 3,
  localparam int BA_W     = $clog2(NUM_BANKS),
  localparam int KEY_W    = BL_W + CL_W + 1
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       cke_i,
  input  logic                       cs_n_i,
  input  logic                       ras_n_i,
  input  logic                       cas_n_i,
  input  logic                       we_n_i,
  input  logic [BA_W-1:0]            ba_i,
  input  logic [ROW_W-1:0]           addr_i,
  output logic [3:0]                 cmd_o,
  output logic                       err_o,
  output logic [NUM_BANKS-1:0]       bank_open_o,
  output logic [NUM_BANKS*ROW_W-1:0] open_row_o,
  output logic [CL_W-1:0]            cas_lat_o,
  output logic [BL_W-1:0]            burst_len_o,
  output logic                       burst_ilv_o,
  output logic                       frozen_o,
  output logic                       self_ref_o
);
  logic                 cke_q;
  cmd_e                 cmd_now;
  cmd_e                 cmd_q;
  logic                 err_q;
  logic [NUM_BANKS-1:0] bank_sel;
  logic [NUM_BANKS-1:0] bank_bad;
  logic                 mode_bad;

  always_ff @(posedge clk) begin
    if (rst) cke_q <= 1'b1;
    else     cke_q <= cke_i;
  end

  sdc_decode u_decode (
    .cke_prev (cke_q),
    .cke_now  (cke_i),
    .cs_n     (cs_n_i),
    .ras_n    (ras_n_i),
    .cas_n    (cas_n_i),
    .we_n     (we_n_i),
    .cmd      (cmd_now)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    assign bank_sel[b] = (ba_i == BA_W'(b));
    sdc_bank #(.ROW_W(ROW_W)) u_bank (
      .clk       (clk),
      .rst       (rst),
      .cmd       (cmd_now),
      .sel       (bank_sel[b]),
      .ap        (addr_i[AP_BIT]),
      .row_in    (addr_i),
      .open_o    (bank_open_o[b]),
      .row_o     (open_row_o[b*ROW_W +: ROW_W]),
      .illegal_o (bank_bad[b])
    );
  end

  sdc_mode #(.BL_W(BL_W), .CL_W(CL_W)) u_mode (
    .clk         (clk),
    .rst         (rst),
    .cmd         (cmd_now),
    .cke_prev    (cke_q),
    .cke_now     (cke_i),
    .any_open    (|bank_open_o),
    .key         (addr_i[KEY_W-1:0]),
    .cas_lat_o   (cas_lat_o),
    .burst_len_o (burst_len_o),
    .burst_ilv_o (burst_ilv_o),
    .self_ref_o  (self_ref_o),
    .illegal_o   (mode_bad)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q <= CMD_NOP;
      err_q <= 1'b0;
    end else begin
      cmd_q <= cmd_now;
      err_q <= mode_bad || (|bank_bad);
    end
  end

  assign cmd_o    = cmd_q;
  assign err_o    = err_q;
  assign frozen_o = ~cke_q;

  assert_frozen_is_nop_R3: assert property (@(posedge clk) disable iff (rst)
    frozen_o |=> (cmd_o == CMD_NOP));

  assert_deselect_is_nop_R2: assert property (@(posedge clk) disable iff (rst)
    cs_n_i |=> (cmd_o == CMD_NOP));

  assert_sref_implies_frozen_R9: assert property (@(posedge clk) disable iff (rst)
    self_ref_o |-> frozen_o);

  assert_one_bank_selected_R10: assert property (@(posedge clk) disable iff (rst)
    $countones(bank_sel) == 1);
endmodule

// File: tb/test_sdram_cmd_tracker.sv
`timescale 1ns/1ps
module test_sdram_cmd_tracker;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cke_i = 1'b1, cs_n_i = 1'b1, ras_n_i = 1'b1, cas_n_i = 1'b1, we_n_i = 1'b1;
  logic [1:0]  ba_i = '0;
  logic [11:0] addr_i = '0;
  logic [3:0]  cmd_o;
  logic        err_o;
  logic [3:0]  bank_open_o;
  logic [47:0] open_row_o;
  logic [2:0]  cas_lat_o, burst_len_o;
  logic        burst_ilv_o, frozen_o, self_ref_o;

  always #2 clk = ~clk;

  sdram_cmd_tracker i_sdram_cmd_tracker (
    .clk(clk), .rst(rst), .cke_i(cke_i), .cs_n_i(cs_n_i), .ras_n_i(ras_n_i),
    .cas_n_i(cas_n_i), .we_n_i(we_n_i), .ba_i(ba_i), .addr_i(addr_i),
    .cmd_o(cmd_o), .err_o(err_o), .bank_open_o(bank_open_o), .open_row_o(open_row_o),
    .cas_lat_o(cas_lat_o), .burst_len_o(burst_len_o), .burst_ilv_o(burst_ilv_o),
    .frozen_o(frozen_o), .self_ref_o(self_ref_o)
  );

  typedef struct {
    logic [3:0]  cmd;
    logic        err;
    logic [3:0]  open;
    logic [47:0] rows;
    logic [2:0]  cl, bl;
    logic        ilv, frz, sr;
    string       req;
  } exp_t;

  exp_t q[$];
  exp_t e;
  int checks = 0, failures = 0;
  bit done = 0;

  logic        m_cke = 1'b1;
  logic [3:0]  m_open = '0;
  logic [11:0] m_row [4] = '{default: '0};
  logic [2:0]  m_cl = 3'd2, m_bl = 3'd0;
  logic        m_ilv = 1'b0, m_sr = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [47:0] act, input logic [47:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic step(input logic cke, input logic cs_n, input logic [2:0] rcw,
                      input logic [1:0] ba, input logic [11:0] a, input string req);
    exp_t x;
    logic [3:0] c;
    logic err;
    @(negedge clk);
    cke_i = cke; cs_n_i = cs_n; {ras_n_i, cas_n_i, we_n_i} = rcw; ba_i = ba; addr_i = a;
    c = 4'd0;
    if (m_cke && !cs_n) begin
      case (rcw)
        3'b000: c = 4'd1;
        3'b001: c = cke ? 4'd2 : 4'd3;
        3'b011: c = 4'd4;
        3'b101: c = 4'd5;
        3'b100: c = 4'd6;
        3'b110: c = 4'd7;
        3'b010: c = 4'd8;
        default: c = 4'd0;
      endcase
    end
    err = 1'b0;
    if (!m_cke && cke) m_sr = 1'b0;
    case (c)
      4'd1: if (|m_open) err = 1'b1; else begin m_cl = a[6:4]; m_bl = a[2:0]; m_ilv = a[3]; end
      4'd2: err = |m_open;
      4'd3: if (|m_open) err = 1'b1; else m_sr = 1'b1;
      4'd4: if (m_open[ba]) err = 1'b1; else begin m_open[ba] = 1'b1; m_row[ba] = a; end
      4'd5, 4'd6: if (!m_open[ba]) err = 1'b1; else if (a[10]) m_open[ba] = 1'b0;
      4'd8: if (a[10]) m_open = '0; else if (!m_open[ba]) err = 1'b1; else m_open[ba] = 1'b0;
      default: ;
    endcase
    m_cke = cke;
    x.cmd = c; x.err = err; x.open = m_open;
    x.rows = {m_row[3], m_row[2], m_row[1], m_row[0]};
    x.cl = m_cl; x.bl = m_bl; x.ilv = m_ilv; x.frz = !cke; x.sr = m_sr; x.req = req;
    @(posedge clk);
    #1;
    q.push_back(x);
  endtask

  // monitor: compares each expected item one half cycle after its edge
  initial forever begin
    @(negedge clk);
    if (q.size() > 0) begin
      e = q.pop_front();
      check(cmd_o == e.cmd, e.req, "cmd", 48'(cmd_o), 48'(e.cmd));
      check(err_o == e.err, e.req, "err", 48'(err_o), 48'(e.err));
      check(bank_open_o == e.open, e.req, "open", 48'(bank_open_o), 48'(e.open));
      check(open_row_o == e.rows, e.req, "rows", open_row_o, e.rows);
      check({cas_lat_o, burst_len_o, burst_ilv_o} == {e.cl, e.bl, e.ilv}, e.req, "mode",
            48'({cas_lat_o, burst_len_o, burst_ilv_o}), 48'({e.cl, e.bl, e.ilv}));
      check({frozen_o, self_ref_o} == {e.frz, e.sr}, e.req, "frz/sref",
            48'({frozen_o, self_ref_o}), 48'({e.frz, e.sr}));
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  localparam logic [2:0] NOP = 3'b111, MRS = 3'b000, REF = 3'b001, ACT = 3'b011,
                         RD = 3'b101, WR = 3'b100, BST = 3'b110, PRE = 3'b010;

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    check(cmd_o == 4'd0 && err_o == 1'b0 && bank_open_o == 4'd0, "R1", "cmd/err/open",
          48'({cmd_o, err_o, bank_open_o}), 48'd0);
    check(open_row_o == 48'd0, "R1", "rows", open_row_o, 48'd0);
    check({cas_lat_o, burst_len_o, burst_ilv_o, frozen_o, self_ref_o} == 9'b010_000_0_0_0,
          "R1", "mode/frz/sref", 48'({cas_lat_o, burst_len_o, burst_ilv_o, frozen_o, self_ref_o}),
          48'(9'b010_000_0_0_0));
    rst = 1'b0;
    step(1, 0, NOP, 2'd0, 12'h000, "R2_nop");
    step(1, 1, ACT, 2'd1, 12'h321, "R2_deselect");
    step(1, 0, MRS, 2'd0, 12'h03A, "R7_load");
    step(1, 0, ACT, 2'd2, 12'hABC, "R4_R10_act_bank2");
    step(1, 0, ACT, 2'd2, 12'h123, "R4_act_open_err");
    step(1, 0, MRS, 2'd0, 12'h045, "R7_blocked");
    step(1, 0, REF, 2'd0, 12'h000, "R8_open_err");
    step(1, 0, RD,  2'd1, 12'h000, "R5_rd_idle_err");
    step(1, 0, WR,  2'd2, 12'h010, "R5_wr_keep_open");
    step(1, 0, ACT, 2'd0, 12'h5A5, "R10_act_bank0");
    step(1, 0, BST, 2'd0, 12'h000, "R2_bst");
    step(1, 0, RD,  2'd0, 12'h400, "R5_rd_autopre");
    step(1, 0, PRE, 2'd0, 12'h000, "R6_pre_idle_err");
    step(1, 0, ACT, 2'd3, 12'hFFF, "R10_act_bank3");
    step(0, 0, NOP, 2'd0, 12'h000, "R3_freeze");
    step(0, 0, PRE, 2'd0, 12'h400, "R3_frozen_ignored");
    step(1, 0, PRE, 2'd3, 12'h000, "R3_release_ignored");
    step(1, 0, PRE, 2'd3, 12'h000, "R6_pre_single");
    step(1, 0, PRE, 2'd1, 12'h400, "R6_pre_all");
    step(1, 0, PRE, 2'd1, 12'h400, "R6_pre_all_idle");
    step(1, 0, REF, 2'd0, 12'h000, "R8_refresh_ok");
    step(0, 0, REF, 2'd0, 12'h000, "R9_sref_enter");
    step(0, 1, NOP, 2'd0, 12'h000, "R9_sref_hold");
    step(1, 1, NOP, 2'd0, 12'h000, "R9_sref_exit");
    step(1, 0, ACT, 2'd1, 12'h777, "R10_act_bank1");
    step(0, 0, REF, 2'd0, 12'h000, "R9_sref_open_err");
    step(1, 0, NOP, 2'd0, 12'h000, "R3_unfreeze");
    step(1, 0, WR,  2'd1, 12'h400, "R5_wr_autopre");
    step(1, 0, MRS, 2'd0, 12'h023, "R7_reload");
    step(1, 0, NOP, 2'd0, 12'h000, "R7_hold");
    repeat (3) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule